// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and an auxiliary microcontroller. The host writes up to four words of payload into a write buffer, programs a source and a destination pointer, then writes a command word. Accepting that command word raises a busy flag and sends a one-cycle doorbell pulse to the controller core. The controller reads the command, the pointers and the payload, places any reply in a four-word read buffer, and ends the exchange with a completion strobe that carries an error flag and an 8-bit error code.

The host polls a status word until busy reads 0 and only then looks at the error flag. When the accepted command asked for it, completion also sends the host a one-cycle interrupt pulse. Host reads are combinational from the registered state: the read data for an address is valid in the same cycle the address is presented.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word, both pointers, every buffer word, the doorbell and the host interrupt are all 0.
- R2: A host write to byte offset 0x00 while busy is 0 is accepted at that clock edge: from the next cycle the status word reads busy (bit 0) as 1 with bits [7:4] equal to command bits [15:12], and the controller command output equals the written word.
- R3: The doorbell output is high for exactly the one cycle that follows the edge accepting a command.
- R4: A command write while busy is 1 is ignored: no doorbell follows and the controller command output keeps its value.
- R5: A completion strobe while busy is 1 clears busy and latches the error flag into status bit 1 and the error code into status bits [23:16]; a completion strobe while busy is 0 changes nothing; an accepted command clears the error flag and error code.
- R6: If bit 8 of the accepted command is 1, the host interrupt is high for exactly the one cycle after the completing edge; if bit 8 is 0 it stays low.
- R7: Host writes to 0x80 + 4*i (i = 0..3) with all four byte strobes set store word i of the write buffer, readable by the host at that offset and by the controller at index i; writes there with any strobe clear are dropped.
- R8: A controller write to read-buffer word i takes effect only while busy is 1 and is read by the host at 0x90 + 4*i; host writes to 0x90..0x9F are ignored.
- R9: Host writes to 0x08 (source pointer) and 0x0C (destination pointer) update only the bytes whose strobes are set; both values read back at those offsets and appear on the controller outputs.
- R10: Reads of offset 0x00, of unmapped offsets and of any address with bits [1:0] nonzero return 0; host writes to the status offset and to unmapped offsets change no state.
- R11: Status bits [15:8] always read the initiator id parameter; bits [3:2] and [31:24] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host byte address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte strobes |
| host_rdata | output | 32 | Host read data for host_addr |
| host_irq | output | 1 | One-cycle completion interrupt to host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to controller |
| ctl_cmd | output | 32 | Last accepted command word |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_wbuf_idx | input | IDX_W | Controller write-buffer word index |
| ctl_wbuf_data | output | 32 | Write-buffer word at ctl_wbuf_idx |
| ctl_rbuf_we | input | 1 | Controller read-buffer write enable |
| ctl_rbuf_idx | input | IDX_W | Controller read-buffer word index |
| ctl_rbuf_data | input | 32 | Controller read-buffer write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Error flag carried with completion |
| ctl_err_code | input | 8 | Error code carried with completion |

## Verification
Every state change lands at the edge that samples the stimulus, so status, pointer and buffer contents are due on host_rdata and the controller outputs one cycle after the write or strobe, and the doorbell and host interrupt are high for that one cycle only. The bench keeps a behavioural model updated at each rising edge from the same inputs and compares every output at the falling edge, while inputs change two nanoseconds after the falling edge, so each comparison sees exactly one edge's worth of change. Directed reads set the address and sample one nanosecond later, well away from any rising edge.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CODE_W = 8;

    // command word field positions
    localparam int unsigned CMD_IOC_BIT = 8;
    localparam int unsigned CMD_ID_LSB  = 12;
    localparam int unsigned CMD_ID_W    = 4;

    // fixed byte offsets of the host map
    localparam int unsigned OFS_CMD  = 'h00;
    localparam int unsigned OFS_STAT = 'h04;
    localparam int unsigned OFS_SPTR = 'h08;
    localparam int unsigned OFS_DPTR = 'h0C;
    localparam int unsigned OFS_WBUF = 'h80;
    localparam int unsigned OFS_RBUF = 'h90;

    typedef enum logic [2:0] {
        RGN_CMD,
        RGN_STAT,
        RGN_SPTR,
        RGN_DPTR,
        RGN_WBUF,
        RGN_RBUF,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic              busy;
        logic              err;
        logic [CODE_W-1:0] err_code;
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] sptr;
        logic [WORD_W-1:0] dptr;
        logic              doorbell;
        logic              host_irq;
    } mbox_state_t;

endpackage

// File: rtl/ipc_mbox_wordbuf.sv
module ipc_mbox_wordbuf #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [W-1:0]              wr_data,
    output logic [DEPTH-1:0][W-1:0]   words
);

    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign words = mem_q;

endmodule

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
    import ipc_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              sptr_wr,
    input  logic              dptr_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [3:0]        be,
    input  logic              done,
    input  logic              done_err,
    input  logic [CODE_W-1:0] done_code,
    output mbox_state_t       st_q
);

    mbox_state_t st_d;

    always_comb begin
        st_d          = st_q;
        st_d.doorbell = 1'b0;
        st_d.host_irq = 1'b0;

        if (cmd_wr && !st_q.busy) begin
            st_d.cmd      = wdata;
            st_d.busy     = 1'b1;
            st_d.err      = 1'b0;
            st_d.err_code = '0;
            st_d.doorbell = 1'b1;
        end else if (done && st_q.busy) begin
            st_d.busy     = 1'b0;
            st_d.err      = done_err;
            st_d.err_code = done_code;
            st_d.host_irq = st_q.cmd[CMD_IOC_BIT];
        end

        for (int b = 0; b < 4; b++) begin
            if (sptr_wr && be[b]) begin
                st_d.sptr[8*b +: 8] = wdata[8*b +: 8];
            end
            if (dptr_wr && be[b]) begin
                st_d.dptr[8*b +: 8] = wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned BUF_WORDS    = 4,
    parameter logic [7:0]  INITIATOR_ID = 8'h01,
    localparam int unsigned IDX_W       = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    input  logic [3:0]        host_be,
    output logic [31:0]       host_rdata,
    output logic              host_irq,
    output logic              ctl_doorbell,
    output logic [31:0]       ctl_cmd,
    output logic [31:0]       ctl_sptr,
    output logic [31:0]       ctl_dptr,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    output logic [31:0]       ctl_wbuf_data,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [31:0]       ctl_rbuf_data,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code
);

    localparam int unsigned BUF_BYTES = 4 * BUF_WORDS;

    mbox_state_t st_q;
    region_e     rgn;
    logic [IDX_W-1:0] host_idx;
    logic [BUF_WORDS-1:0][31:0] wbuf_words, rbuf_words;
    logic        mbox_busy;
    logic [31:0] status_word;

    // address decode: misaligned addresses map nowhere
    always_comb begin
        rgn = RGN_NONE;
        if (host_addr[1:0] == 2'b00) begin
            if (host_addr == ADDR_W'(OFS_CMD))       rgn = RGN_CMD;
            else if (host_addr == ADDR_W'(OFS_STAT)) rgn = RGN_STAT;
            else if (host_addr == ADDR_W'(OFS_SPTR)) rgn = RGN_SPTR;
            else if (host_addr == ADDR_W'(OFS_DPTR)) rgn = RGN_DPTR;
            else if (host_addr >= ADDR_W'(OFS_WBUF) &&
                     host_addr <  ADDR_W'(OFS_WBUF + BUF_BYTES)) rgn = RGN_WBUF;
            else if (host_addr >= ADDR_W'(OFS_RBUF) &&
                     host_addr <  ADDR_W'(OFS_RBUF + BUF_BYTES)) rgn = RGN_RBUF;
        end
    end

    assign host_idx = host_addr[IDX_W+1:2];

    ipc_mbox_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (host_we && rgn == RGN_CMD),
        .sptr_wr   (host_we && rgn == RGN_SPTR),
        .dptr_wr   (host_we && rgn == RGN_DPTR),
        .wdata     (host_wdata),
        .be        (host_be),
        .done      (ctl_done),
        .done_err  (ctl_err),
        .done_code (ctl_err_code),
        .st_q      (st_q)
    );

    ipc_mbox_wordbuf #(.DEPTH(BUF_WORDS), .W(32)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_we && rgn == RGN_WBUF && host_be == 4'hF),
        .wr_idx  (host_idx),
        .wr_data (host_wdata),
        .words   (wbuf_words)
    );

    ipc_mbox_wordbuf #(.DEPTH(BUF_WORDS), .W(32)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_rbuf_we && st_q.busy),
        .wr_idx  (ctl_rbuf_idx),
        .wr_data (ctl_rbuf_data),
        .words   (rbuf_words)
    );

    assign mbox_busy   = st_q.busy;
    assign status_word = {8'h00, st_q.err_code, INITIATOR_ID,
                          st_q.cmd[CMD_ID_LSB +: CMD_ID_W], 2'b00,
                          st_q.err, st_q.busy};

    always_comb begin
        unique case (rgn)
            RGN_STAT: host_rdata = status_word;
            RGN_SPTR: host_rdata = st_q.sptr;
            RGN_DPTR: host_rdata = st_q.dptr;
            RGN_WBUF: host_rdata = wbuf_words[host_idx];
            RGN_RBUF: host_rdata = rbuf_words[host_idx];
            default:  host_rdata = '0;
        endcase
    end

    assign host_irq      = st_q.host_irq;
    assign ctl_doorbell  = st_q.doorbell;
    assign ctl_cmd       = st_q.cmd;
    assign ctl_sptr      = st_q.sptr;
    assign ctl_dptr      = st_q.dptr;
    assign ctl_wbuf_data = wbuf_words[ctl_wbuf_idx];

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_doorbell,
    input logic        host_irq,
    input logic        mbox_busy,
    input logic        ctl_done,
    input logic [31:0] ctl_cmd
);

    // R2: a doorbell only follows an accepted command, so busy is up
    p_doorbell_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |-> mbox_busy);

    // R3: doorbell lasts one cycle
    p_doorbell_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |=> !ctl_doorbell);

    // R4: no doorbell while a command is outstanding
    p_no_ring_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_busy |=> !ctl_doorbell);

    // R4: command held while busy
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_busy && $past(mbox_busy)) |-> $stable(ctl_cmd));

    // R5: completion clears busy
    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && mbox_busy) |=> !mbox_busy);

    // R6: host interrupt is a single cycle caused by completion
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(ctl_done && mbox_busy));

endmodule

bind ipc_mailbox ipc_mailbox_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_doorbell (ctl_doorbell),
    .host_irq     (host_irq),
    .mbox_busy    (mbox_busy),
    .ctl_done     (ctl_done),
    .ctl_cmd      (ctl_cmd)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

    localparam logic [7:0] INIT_ID = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_rdata;
    logic        host_irq, ctl_doorbell;
    logic [31:0] ctl_cmd, ctl_sptr, ctl_dptr, ctl_wbuf_data;
    logic [1:0]  ctl_wbuf_idx = '0;
    logic        ctl_rbuf_we = 1'b0;
    logic [1:0]  ctl_rbuf_idx = '0;
    logic [31:0] ctl_rbuf_data = '0;
    logic        ctl_done = 1'b0, ctl_err = 1'b0;
    logic [7:0]  ctl_err_code = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ipc_mailbox #(.ADDR_W(8), .BUF_WORDS(4), .INITIATOR_ID(INIT_ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_be(host_be), .host_rdata(host_rdata),
        .host_irq(host_irq), .ctl_doorbell(ctl_doorbell), .ctl_cmd(ctl_cmd),
        .ctl_sptr(ctl_sptr), .ctl_dptr(ctl_dptr), .ctl_wbuf_idx(ctl_wbuf_idx),
        .ctl_wbuf_data(ctl_wbuf_data), .ctl_rbuf_we(ctl_rbuf_we),
        .ctl_rbuf_idx(ctl_rbuf_idx), .ctl_rbuf_data(ctl_rbuf_data),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
    );

    // ---------------- behavioural reference model ----------------
    logic        m_busy, m_err, m_db, m_irq;
    logic [7:0]  m_code;
    logic [31:0] m_cmd, m_sptr, m_dptr;
    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_err <= 0; m_db <= 0; m_irq <= 0; m_code <= 0;
            m_cmd <= 0; m_sptr <= 0; m_dptr <= 0;
            for (int i = 0; i < 4; i++) begin
                m_wbuf[i] <= 0;
                m_rbuf[i] <= 0;
            end
        end else begin
            m_db  <= 0;
            m_irq <= 0;
            if (host_we) begin
                if (host_addr == 8'h00 && !m_busy) begin
                    m_cmd <= host_wdata; m_busy <= 1; m_err <= 0; m_code <= 0; m_db <= 1;
                end
                for (int b = 0; b < 4; b++) begin
                    if (host_be[b] && host_addr == 8'h08) m_sptr[8*b +: 8] <= host_wdata[8*b +: 8];
                    if (host_be[b] && host_addr == 8'h0C) m_dptr[8*b +: 8] <= host_wdata[8*b +: 8];
                end
                if (host_addr >= 8'h80 && host_addr <= 8'h8C && host_addr[1:0] == 0 && host_be == 4'hF)
                    m_wbuf[host_addr[3:2]] <= host_wdata;
            end
            if (ctl_rbuf_we && m_busy) m_rbuf[ctl_rbuf_idx] <= ctl_rbuf_data;
            if (ctl_done && m_busy) begin
                m_busy <= 0; m_err <= ctl_err; m_code <= ctl_err_code; m_irq <= m_cmd[8];
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[1:0] != 0)               return 32'h0;
        if (a == 8'h04)                return {8'h0, m_code, INIT_ID, m_cmd[15:12], 2'b00, m_err, m_busy};
        if (a == 8'h08)                return m_sptr;
        if (a == 8'h0C)                return m_dptr;
        if (a >= 8'h80 && a <= 8'h8C)  return m_wbuf[a[3:2]];
        if (a >= 8'h90 && a <= 8'h9C)  return m_rbuf[a[3:2]];
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h04) return "R5";
        if (a == 8'h08 || a == 8'h0C) return "R9";
        if (a[1:0] == 0 && a >= 8'h80 && a <= 8'h8C) return "R7";
        if (a[1:0] == 0 && a >= 8'h90 && a <= 8'h9C) return "R8";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3", 32'(ctl_doorbell), 32'(m_db));
            check("R6", 32'(host_irq), 32'(m_irq));
            check("R2", ctl_cmd, m_cmd);
            check("R9", ctl_sptr, m_sptr);
            check("R9", ctl_dptr, m_dptr);
            check("R7", ctl_wbuf_data, m_wbuf[ctl_wbuf_idx]);
            check(tag_of(host_addr), host_rdata, exp_rd(host_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk); #2;
        host_addr = a; host_we = 1; host_wdata = d; host_be = be;
        @(negedge clk); #2;
        host_we = 0; host_be = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #2;
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic ctl_put(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk); #2;
        ctl_rbuf_we = 1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
        @(negedge clk); #2;
        ctl_rbuf_we = 0;
    endtask

    task automatic ctl_finish(input logic e, input logic [7:0] code);
        @(negedge clk); #2;
        ctl_done = 1; ctl_err = e; ctl_err_code = code;
        @(negedge clk); #2;
        ctl_done = 0; ctl_err = 0; ctl_err_code = 0;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;

        // R1: reset state
        check("R1", 32'(ctl_doorbell), 0);
        check("R1", 32'(host_irq), 0);
        rd_chk(8'h04, 32'h0000_0100, "R1");
        rd_chk(8'h08, 32'h0, "R1");
        rd_chk(8'h8C, 32'h0, "R1");
        rd_chk(8'h90, 32'h0, "R1");

        // R7: write buffer, full and partial strobes
        hwr(8'h80, 32'h1111_0000, 4'hF);
        hwr(8'h84, 32'h2222_0001, 4'hF);
        hwr(8'h88, 32'h3333_0002, 4'hF);
        hwr(8'h8C, 32'h4444_0003, 4'hF);
        hwr(8'h84, 32'h5555_5555, 4'b0011);
        rd_chk(8'h84, 32'h2222_0001, "R7");
        @(negedge clk); #2 ctl_wbuf_idx = 2'd2;
        #1 check("R7", ctl_wbuf_data, 32'h3333_0002);

        // R9: byte-strobed pointers
        hwr(8'h08, 32'hAABB_CCDD, 4'hF);
        hwr(8'h08, 32'h1122_3344, 4'b0101);
        rd_chk(8'h08, 32'hAA22_CC44, "R9");
        hwr(8'h0C, 32'h0BAD_F00D, 4'b1000);
        rd_chk(8'h0C, 32'h0B00_0000, "R9");

        // R10/R8: ignored writes, zero reads
        hwr(8'h04, 32'hFFFF_FFFF, 4'hF);
        hwr(8'h40, 32'hFFFF_FFFF, 4'hF);
        hwr(8'h94, 32'hFFFF_FFFF, 4'hF);
        rd_chk(8'h04, 32'h0000_0100, "R10");
        rd_chk(8'h40, 32'h0, "R10");
        rd_chk(8'h94, 32'h0, "R8");
        rd_chk(8'h81, 32'h0, "R10");

        // R2/R3/R11: accept a command with completion interrupt requested
        hwr(8'h00, 32'h0010_5142, 4'hF);
        check("R3", 32'(ctl_doorbell), 1);
        check("R2", ctl_cmd, 32'h0010_5142);
        rd_chk(8'h04, 32'h0000_0151, "R11");
        rd_chk(8'h00, 32'h0, "R10");

        // R4: second command while busy
        hwr(8'h00, 32'hFFFF_FFFF, 4'hF);
        check("R4", 32'(ctl_doorbell), 0);
        check("R4", ctl_cmd, 32'h0010_5142);

        // R8: controller fills read buffer while busy
        for (int i = 0; i < 4; i++) ctl_put(2'(i), 32'hC0DE_0000 + 32'(i));
        rd_chk(8'h9C, 32'hC0DE_0003, "R8");

        // R5/R6: completion with error
        ctl_finish(1'b1, 8'h3C);
        check("R6", 32'(host_irq), 1);
        rd_chk(8'h04, 32'h003C_0152, "R5");

        // R5/R8: strobes while idle are ignored
        ctl_finish(1'b0, 8'h77);
        ctl_put(2'd0, 32'hDEAD_BEEF);
        rd_chk(8'h04, 32'h003C_0152, "R5");
        rd_chk(8'h90, 32'hC0DE_0000, "R8");

        // R5/R6: new command clears error, no interrupt requested
        hwr(8'h00, 32'h0000_2007, 4'hF);
        rd_chk(8'h04, 32'h0000_0121, "R5");
        ctl_finish(1'b0, 8'h00);
        check("R6", 32'(host_irq), 0);
        rd_chk(8'h04, 32'h0000_0120, "R5");

        // sweep every aligned offset through the per-cycle comparison
        for (int a = 0; a < 256; a += 4) begin
            @(negedge clk); #2 host_addr = 8'(a);
        end
        @(negedge clk);
        report();
    end

endmodule